// File: doc/BRIEF.md
# 32-bit Integer ALU with Four-Bit Operation Code

This block is a purely combinational integer arithmetic and logic unit for a simple processor datapath. Two operands of `W` bits (32 by default) and a four-bit operation code select one of ten operations:

- signed and unsigned addition;
- signed and unsigned subtraction;
- four bitwise logic functions;
- signed and unsigned set-on-less-than.

The block returns a `W`-bit result, a flag that is high when that result is all zeros, and a signed-overflow flag.

Operands arrive fully formed: any immediate has already been sign- or zero-extended upstream. One ripple adder serves every arithmetic code. Subtraction feeds it the inverted second operand with a carry-in of one. The less-than codes read their answer from that same subtraction rather than from a separate comparator. The overflow flag is only reported. Deciding whether to trap on it is left to surrounding control.

Top module: `int_alu`

## Requirements
- R1: Code 0 (signed add) and code 1 (unsigned add) return (opa + opb) modulo 2^W.
- R2: Code 2 (signed subtract) and code 3 (unsigned subtract) return (opa - opb) modulo 2^W, formed as opa + ~opb + 1.
- R3: Codes 4, 5, 6 and 7 return bitwise opa AND opb, OR, XOR and NOR respectively, each bit depending only on the two operand bits at its own position.
- R4: ovf_flag is 0 for every code other than 0 and 2, including unsigned add and unsigned subtract.
- R5: For codes 0 and 2, ovf_flag is 1 exactly when the true signed sum or difference lies outside the two's-complement range of W bits; this equals the carry into the top bit XOR the carry out of it.
- R6: Code 0xA returns 1 in bit 0 when opa < opb as signed numbers, including when opa - opb overflows; bits W-1..1 are 0.
- R7: Code 0xB returns 1 in bit 0 when opa < opb as unsigned numbers (the subtraction produces no carry out); bits W-1..1 are 0.
- R8: zero_flag is 1 exactly when every bit of res is 0.
- R9: Codes 8, 9 and 0xC to 0xF return res = 0 and ovf_flag = 0, so zero_flag is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| opcode | input | 4 | Operation select code |
| res | output | W | Operation result |
| zero_flag | output | 1 | High when res is all zeros |
| ovf_flag | output | 1 | Signed overflow of codes 0 and 2 |

## Verification
The sweeps concentrate on operands at the edges of the signed range: the most negative value, the most positive value, minus one and their neighbours, paired with every code. A design that took the signed comparison from the sign of the difference alone would report the wrong order for pairs such as most-negative against one, where the subtraction wraps. A design that leaked the raw overflow signal onto the unsigned or logic codes would flag ordinary wraparound of unsigned sums. A 4-bit instance is swept over every operand pair and code, so a fault that lies in the carry chain or in the unused-code decode cannot hide between sampled values.

// File: rtl/int_alu.sv
module int_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [3:0]   opcode,
  output logic [W-1:0] res,
  output logic         zero_flag,
  output logic         ovf_flag
);

  localparam logic [3:0] C_ADD  = 4'h0;
  localparam logic [3:0] C_ADDU = 4'h1;
  localparam logic [3:0] C_SUB  = 4'h2;
  localparam logic [3:0] C_SUBU = 4'h3;
  localparam logic [3:0] C_AND  = 4'h4;
  localparam logic [3:0] C_OR   = 4'h5;
  localparam logic [3:0] C_XOR  = 4'h6;
  localparam logic [3:0] C_NOR  = 4'h7;
  localparam logic [3:0] C_SLT  = 4'hA;
  localparam logic [3:0] C_SLTU = 4'hB;

  logic         negate_b;
  logic [W-1:0] b_in;
  logic [W-1:0] sum;
  logic         carry_msb_in;
  logic         carry_out;
  logic         raw_ovf;
  logic         less_signed;
  logic         less_unsigned;

  assign negate_b = (opcode == C_SUB) || (opcode == C_SUBU) ||
                    (opcode == C_SLT) || (opcode == C_SLTU);
  assign b_in = opb ^ {W{negate_b}};

  always_comb begin
    logic c;
    c            = negate_b;
    carry_msb_in = 1'b0;
    sum          = '0;
    for (int i = 0; i < W; i++) begin
      if (i == W - 1) carry_msb_in = c;
      sum[i] = opa[i] ^ b_in[i] ^ c;
      c      = (opa[i] & b_in[i]) | (opa[i] & c) | (b_in[i] & c);
    end
    carry_out = c;
  end

  assign raw_ovf       = carry_msb_in ^ carry_out;
  assign less_signed   = sum[W-1] ^ raw_ovf;
  assign less_unsigned = ~carry_out;

  always_comb begin
    res = '0;
    unique case (opcode)
      C_ADD, C_ADDU, C_SUB, C_SUBU: res = sum;
      C_AND:  res = opa & opb;
      C_OR:   res = opa | opb;
      C_XOR:  res = opa ^ opb;
      C_NOR:  res = ~(opa | opb);
      C_SLT:  res = {{(W-1){1'b0}}, less_signed};
      C_SLTU: res = {{(W-1){1'b0}}, less_unsigned};
      default: res = '0;
    endcase
  end

  assign ovf_flag  = ((opcode == C_ADD) || (opcode == C_SUB)) & raw_ovf;
  assign zero_flag = ~|res;

endmodule

// File: rtl/int_alu_chk.sv
module int_alu_chk #(
  parameter int W = 32
) (
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic [3:0]   opcode,
  input logic [W-1:0] res,
  input logic         zero_flag,
  input logic         ovf_flag
);

  always_comb begin
    AST_OVF_ONLY_SIGNED: assert (!ovf_flag || opcode == 4'h0 || opcode == 4'h2); // R4
    AST_ADD_OVF_SIGNS: assert (!(opcode == 4'h0 && ovf_flag) ||
                               (opa[W-1] == opb[W-1] && res[W-1] != opa[W-1])); // R5
    AST_SET_UPPER_CLEAR: assert (!(opcode == 4'hA || opcode == 4'hB) || res[W-1:1] == '0); // R6
    AST_SELF_SUB_ZERO: assert (!((opcode == 4'h2 || opcode == 4'h3) && opa == opb) ||
                               (zero_flag && !ovf_flag)); // R8
    AST_UNUSED_CODE: assert (!(opcode == 4'h8 || opcode == 4'h9 || opcode >= 4'hC) ||
                             (res == '0 && !ovf_flag && zero_flag)); // R9
  end

endmodule

bind int_alu int_alu_chk #(.W(W)) u_chk (
  .opa(opa), .opb(opb), .opcode(opcode),
  .res(res), .zero_flag(zero_flag), .ovf_flag(ovf_flag)
);

// File: tb/int_alu_bench.sv
module int_alu_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [31:0] a32, b32, r32;
  logic [3:0]  op32;
  logic        z32, v32;
  logic [3:0]  a4, b4, r4;
  logic [3:0]  op4;
  logic        z4, v4;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int_alu #(.W(32)) u_int_alu (
    .opa(a32), .opb(b32), .opcode(op32),
    .res(r32), .zero_flag(z32), .ovf_flag(v32)
  );

  int_alu #(.W(4)) u_int_alu_w4 (
    .opa(a4), .opb(b4), .opcode(op4),
    .res(r4), .zero_flag(z4), .ovf_flag(v4)
  );

  function automatic string tag_of(int op);
    case (op)
      0, 1:             return "R1";
      2, 3:             return "R2";
      4, 5, 6, 7:       return "R3";
      10:               return "R6";
      11:               return "R7";
      default:          return "R9";
    endcase
  endfunction

  task automatic model(input int w, input longint unsigned a, input longint unsigned b,
                       input int op, output longint unsigned r, output bit v);
    longint unsigned mask = (64'd1 << w) - 1;
    longint sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
    longint sb = b[w-1] ? longint'(b) - (longint'(1) << w) : longint'(b);
    longint lo = -(longint'(1) << (w - 1));
    longint hi = (longint'(1) << (w - 1)) - 1;
    longint big;
    v = 0;
    r = 0;
    case (op)
      0: begin big = sa + sb; r = (a + b) & mask; v = (big < lo) || (big > hi); end
      1: r = (a + b) & mask;
      2: begin big = sa - sb; r = (a - b) & mask; v = (big < lo) || (big > hi); end
      3: r = (a - b) & mask;
      4: r = a & b;
      5: r = a | b;
      6: r = a ^ b;
      7: r = ~(a | b) & mask;
      10: r = (sa < sb) ? 1 : 0;
      11: r = (a < b) ? 1 : 0;
      default: r = 0;
    endcase
  endtask

  task automatic cmp(input string tag, input string what, input int w,
                     input longint unsigned a, input longint unsigned b, input int op,
                     input longint unsigned got, input longint unsigned exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s w=%0d op=%0h a=%0h b=%0h actual=%0h expected=%0h",
               tag, what, w, op, a, b, got, exp);
    end
  endtask

  task automatic judge(input int w, input longint unsigned a, input longint unsigned b,
                       input int op, input longint unsigned r, input bit z, input bit v);
    longint unsigned er;
    bit ev;
    model(w, a, b, op, er, ev);
    cmp(tag_of(op), "res", w, a, b, op, r, er);
    cmp((op == 0 || op == 2) ? "R5" : "R4", "ovf", w, a, b, op, v, ev);
    cmp("R8", "zero", w, a, b, op, z, er == 0);
  endtask

  logic [31:0] corner [11];

  initial begin
    corner = '{32'h0, 32'h1, 32'h2, 32'h7fffffff, 32'h80000000, 32'h80000001,
               32'hffffffff, 32'hfffffffe, 32'h55555555, 32'haaaaaaaa, 32'h12345678};
    a32 = 0; b32 = 0; op32 = 0; a4 = 0; b4 = 0; op4 = 0;
    for (int op = 0; op < 16; op++) begin
      for (int i = 0; i < 11; i++) begin
        for (int j = 0; j < 11; j++) begin
          @(negedge clk);
          a32 = corner[i]; b32 = corner[j]; op32 = 4'(op);
          #1;
          judge(32, a32, b32, op, r32, z32, v32);
        end
      end
    end
    for (int op = 0; op < 16; op++) begin
      for (int a = 0; a < 16; a++) begin
        for (int b = 0; b < 16; b++) begin
          @(negedge clk);
          a4 = 4'(a); b4 = 4'(b); op4 = 4'(op);
          #1;
          judge(4, a4, b4, op, r4, z4, v4);
        end
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule